// File: doc/BRIEF.md
# Load-Store Byte-Lane Alignment Unit

This unit sits between a 32-bit processor datapath and a word-wide, byte-addressed, little-endian data memory. For each request it adds a sign-extended 12-bit offset to a base value, giving the effective address. It presents the word-aligned part of that address to the memory and keeps the two low bits as the byte lane. Byte k of a memory word holds bits 8k+7 down to 8k, so the byte at the word's own address is its least-significant byte.

On stores the unit produces the write data and per-byte write enables. A word store drives all four lanes. A byte store copies the low byte of the store data onto every lane and enables only the addressed one. On loads the memory's read word is captured at the clock edge that ends the request cycle, together with the lane and the operation. In the next cycle the unit presents either the whole word or the selected byte, extended with its sign or with zeros.

Word accesses whose effective address is not a multiple of four are flagged, and their writes are blocked. Byte accesses are never flagged.

Top module: `lsu_lane_align`

## Requirements
- R1: `mem_addr` equals `base_val` plus the two's-complement value of `offs_imm`, modulo 2^32, with bits 1..0 forced to zero. It is combinational in the request cycle. The byte lane is bits 1..0 of that sum.
- R2: Operation codes are LW=0, LB=1, LBU=2, SW=3 and SB=4. A valid, aligned SW asserts `wr_en`, sets `byte_en` to 4'b1111 and drives `wr_data` equal to `st_data` in the same cycle.
- R3: A valid SB asserts `wr_en` and sets exactly one `byte_en` bit: bit L, where L is the lane. It drives `st_data[7:0]` onto all four byte positions of `wr_data`.
- R4: A valid LW or SW whose lane is not zero raises `misaligned` and holds `wr_en` low. The memory word is left unchanged. A misaligned LW still returns the word at the aligned address. LB, LBU and SB never raise `misaligned`.
- R5: A valid LB returns, in the cycle after the request, byte L of the word on `mem_rdata` during the request cycle. That byte goes in bits 7..0, and its bit 7 is copied into bits 31..8.
- R6: A valid LBU returns the same byte with bits 31..8 cleared, in the cycle after the request.
- R7: A valid LW returns the full `mem_rdata` word of the request cycle in the next cycle.
- R8: Loads, operation codes 5 to 7, and any cycle with `req_valid` low do not write: `wr_en` is 0 and `byte_en` is 0. Codes 5 to 7 and idle cycles also keep `misaligned` low.
- R9: `load_valid` is high exactly in the cycle after a valid load request, and low otherwise. Without a new load, `load_result` holds its value. After reset `load_valid` is 0 and `load_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (LW=0, LB=1, LBU=2, SW=3, SB=4) |
| base_val | input | 32 | Base register value |
| offs_imm | input | 12 | Signed offset |
| st_data | input | 32 | Store data |
| mem_rdata | input | 32 | Memory read word for `mem_addr` in this cycle |
| mem_addr | output | 32 | Word-aligned memory address |
| wr_data | output | 32 | Lane-placed write data |
| byte_en | output | 4 | Per-byte write enables |
| wr_en | output | 1 | Memory write strobe |
| misaligned | output | 1 | Word access not on a 4-byte boundary |
| load_valid | output | 1 | `load_result` belongs to the previous cycle's load |
| load_result | output | 32 | Extended load value |

## Verification
The load-return path and the store-steering path can be active in the same cycle. A load's extension runs on the lane captured from its own request, while a new request's address, enables and write data are formed combinationally from fresh inputs. The bench issues requests back to back with no idle cycles, including a byte load followed at once by a byte store to a different lane of the same word. In each of those cycles it checks the previous load's result against its own byte arithmetic on a shadow memory, and checks the new store's enables and data against the new lane. A wrong capture of the lane, or a result that leaks from the second request into the first, shows up as a miscompare.

// File: rtl/lsu_lane_pkg.sv
`timescale 1ns/1ps
package lsu_lane_pkg;

  typedef enum logic [2:0] {
    OP_LW  = 3'd0,
    OP_LB  = 3'd1,
    OP_LBU = 3'd2,
    OP_SW  = 3'd3,
    OP_SB  = 3'd4
  } lsu_op_e;

  function automatic logic op_is_load(input logic [2:0] op);
    return (op == OP_LW) || (op == OP_LB) || (op == OP_LBU);
  endfunction

  function automatic logic op_is_store(input logic [2:0] op);
    return (op == OP_SW) || (op == OP_SB);
  endfunction

  function automatic logic op_is_word(input logic [2:0] op);
    return (op == OP_LW) || (op == OP_SW);
  endfunction

  function automatic logic op_is_byte(input logic [2:0] op);
    return (op == OP_LB) || (op == OP_LBU) || (op == OP_SB);
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
`timescale 1ns/1ps
module lsu_addr_gen #(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 12,
  parameter int LANE_W = 2
) (
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [DATA_W-1:0] base_val,
  input  logic [OFFS_W-1:0] offs_imm,
  output logic [DATA_W-1:0] word_addr,
  output logic [LANE_W-1:0] lane,
  output logic              misal
);
  import lsu_lane_pkg::*;

  function automatic logic [DATA_W-1:0] widen_offs(input logic [OFFS_W-1:0] o);
    return {{(DATA_W-OFFS_W){o[OFFS_W-1]}}, o};
  endfunction

  logic [DATA_W-1:0] eff_addr;

  always_comb begin
    eff_addr  = base_val + widen_offs(offs_imm);
    word_addr = {eff_addr[DATA_W-1:LANE_W], {LANE_W{1'b0}}};
    lane      = eff_addr[LANE_W-1:0];
    misal     = req_valid && op_is_word(req_op) && (eff_addr[LANE_W-1:0] != '0);
  end

endmodule

// File: rtl/lsu_store_lane.sv
`timescale 1ns/1ps
module lsu_store_lane #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [LANE_W-1:0] lane,
  input  logic              misal,
  input  logic [DATA_W-1:0] st_data,
  output logic              wr_en,
  output logic [LANES-1:0]  byte_en,
  output logic [DATA_W-1:0] wr_data
);
  import lsu_lane_pkg::*;

  localparam int BYTE_W = DATA_W / LANES;

  logic [DATA_W-1:0] repl_data;

  for (genvar g = 0; g < LANES; g++) begin : g_repl
    assign repl_data[g*BYTE_W +: BYTE_W] = st_data[BYTE_W-1:0];
  end

  function automatic logic [LANES-1:0] lane_mask(input logic [LANE_W-1:0] l);
    return {{(LANES-1){1'b0}}, 1'b1} << l;
  endfunction

  always_comb begin
    wr_en   = req_valid && op_is_store(req_op) && !misal;
    byte_en = '0;
    wr_data = st_data;
    if (req_valid && (req_op == OP_SW)) begin
      byte_en = '1;
    end else if (req_valid && (req_op == OP_SB)) begin
      byte_en = lane_mask(lane);
      wr_data = repl_data;
    end
  end

endmodule

// File: rtl/lsu_load_extract.sv
`timescale 1ns/1ps
module lsu_load_extract #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [2:0]        req_op,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_result
);
  import lsu_lane_pkg::*;

  localparam int BYTE_W = DATA_W / LANES;

  logic [DATA_W-1:0] rdata_q;
  logic [LANE_W-1:0] lane_q;
  logic [2:0]        op_q;
  logic              valid_q;
  logic [BYTE_W-1:0] lane_bytes [LANES];
  logic [BYTE_W-1:0] sel_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      lane_q  <= '0;
      op_q    <= OP_LW;
      valid_q <= 1'b0;
    end else begin
      valid_q <= capture;
      if (capture) begin
        rdata_q <= mem_rdata;
        lane_q  <= lane;
        op_q    <= req_op;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = rdata_q[g*BYTE_W +: BYTE_W];
  end

  assign sel_byte = lane_bytes[lane_q];

  function automatic logic [DATA_W-1:0] extend_byte(input logic [BYTE_W-1:0] b,
                                                    input logic            signed_ext);
    return {{(DATA_W-BYTE_W){signed_ext & b[BYTE_W-1]}}, b};
  endfunction

  always_comb begin
    if (op_q == OP_LW) load_result = rdata_q;
    else               load_result = extend_byte(sel_byte, op_q == OP_LB);
  end

  assign load_valid = valid_q;

endmodule

// File: rtl/lsu_lane_align.sv
`timescale 1ns/1ps
module lsu_lane_align #(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 12,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [DATA_W-1:0] base_val,
  input  logic [OFFS_W-1:0] offs_imm,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  byte_en,
  output logic              wr_en,
  output logic              misaligned,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_result
);
  import lsu_lane_pkg::*;

  localparam int LANE_W = $clog2(LANES);

  // Named internal events, used by the bound checker
  logic [LANE_W-1:0] ea_lane;
  logic              acc_load;
  logic              acc_word;
  logic              acc_byte;
  logic              load_capture;

  assign acc_load     = op_is_load(req_op);
  assign acc_word     = op_is_word(req_op);
  assign acc_byte     = op_is_byte(req_op);
  assign load_capture = req_valid && acc_load;

  lsu_addr_gen #(.DATA_W(DATA_W), .OFFS_W(OFFS_W), .LANE_W(LANE_W)) i_addr (
    .req_valid (req_valid),
    .req_op    (req_op),
    .base_val  (base_val),
    .offs_imm  (offs_imm),
    .word_addr (mem_addr),
    .lane      (ea_lane),
    .misal     (misaligned)
  );

  lsu_store_lane #(.DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)) i_store (
    .req_valid (req_valid),
    .req_op    (req_op),
    .lane      (ea_lane),
    .misal     (misaligned),
    .st_data   (st_data),
    .wr_en     (wr_en),
    .byte_en   (byte_en),
    .wr_data   (wr_data)
  );

  lsu_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)) i_load (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (load_capture),
    .req_op      (req_op),
    .lane        (ea_lane),
    .mem_rdata   (mem_rdata),
    .load_valid  (load_valid),
    .load_result (load_result)
  );

endmodule

// File: rtl/lsu_lane_align_chk.sv
`timescale 1ns/1ps
module lsu_lane_align_chk #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              acc_load,
  input logic              acc_word,
  input logic              acc_byte,
  input logic              wr_en,
  input logic [LANES-1:0]  byte_en,
  input logic              misaligned,
  input logic              load_valid,
  input logic [DATA_W-1:0] load_result
);

  p_sw_all_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_word) |-> (byte_en == '1));

  p_sb_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_byte) |-> ($countones(byte_en) == 1));

  p_misal_blocks_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> !wr_en);

  p_byte_never_flagged_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_byte |-> !misaligned);

  p_load_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_load) |-> (!wr_en && (byte_en == '0)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!wr_en && !misaligned && (byte_en == '0)));

  p_load_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_load) |=> load_valid);

  p_load_valid_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && acc_load) |=> !load_valid);

  p_result_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && acc_load) |=> $stable(load_result));

endmodule

bind lsu_lane_align lsu_lane_align_chk #(.DATA_W(DATA_W), .LANES(LANES)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .acc_load    (acc_load),
  .acc_word    (acc_word),
  .acc_byte    (acc_byte),
  .wr_en       (wr_en),
  .byte_en     (byte_en),
  .misaligned  (misaligned),
  .load_valid  (load_valid),
  .load_result (load_result)
);

// File: tb/test_lsu_lane_align.sv
`timescale 1ns/1ps
module test_lsu_lane_align;

  localparam logic [2:0] C_LW = 3'd0, C_LB = 3'd1, C_LBU = 3'd2, C_SW = 3'd3, C_SB = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [31:0] base_val = '0;
  logic [11:0] offs_imm = '0;
  logic [31:0] st_data = '0;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr, wr_data, load_result;
  logic [3:0]  byte_en;
  logic        wr_en, misaligned, load_valid;

  logic [31:0] bmem   [16];
  logic [31:0] shadow [16];

  int n_vec = 0;
  int n_bad = 0;

  logic        exp_lv = 1'b0;
  logic [31:0] exp_lr = '0;
  string       exp_tag = "R7";

  always #2.5 clk = ~clk;

  lsu_lane_align i_lsu_lane_align (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .base_val(base_val), .offs_imm(offs_imm), .st_data(st_data),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .wr_data(wr_data),
    .byte_en(byte_en), .wr_en(wr_en), .misaligned(misaligned),
    .load_valid(load_valid), .load_result(load_result)
  );

  assign mem_rdata = bmem[mem_addr[5:2]];

  always @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < 4; k++)
        if (byte_en[k]) bmem[mem_addr[5:2]][8*k +: 8] <= wr_data[8*k +: 8];
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int w);
    return {8'h80 + 8'(w), 8'h7F - 8'(w), 8'hC3 ^ 8'(w), 8'(w * 8 + 1)};
  endfunction

  // One request per cycle; also judges the previous request's load return
  task automatic issue(input logic v, input logic [2:0] op, input logic [31:0] b,
                       input logic [11:0] off, input logic [31:0] sd);
    logic [31:0] ea, word, xb_wd;
    logic [1:0]  ln;
    logic [7:0]  by;
    logic        is_ld, is_st, is_wd, mis;
    logic [3:0]  xbe;
    @(negedge clk);
    req_valid = v; req_op = op; base_val = b; offs_imm = off; st_data = sd;
    #1;
    chk(load_valid === exp_lv, "R9 load_valid", {31'd0, load_valid}, {31'd0, exp_lv});
    if (exp_lv) chk(load_result === exp_lr, exp_tag, load_result, exp_lr);

    ea    = b + {{20{off[11]}}, off};
    ln    = ea[1:0];
    is_ld = v && (op == C_LW || op == C_LB || op == C_LBU);
    is_st = v && (op == C_SW || op == C_SB);
    is_wd = (op == C_LW || op == C_SW);
    mis   = v && is_wd && (ln != 2'd0);
    chk(mem_addr === {ea[31:2], 2'b00}, "R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
    chk(misaligned === mis, "R4 misaligned", {31'd0, misaligned}, {31'd0, mis});
    if (is_st && op == C_SW) begin
      chk(wr_en === !mis, mis ? "R4 wr_en blocked" : "R2 wr_en", {31'd0, wr_en}, {31'd0, !mis});
      if (!mis) begin
        chk(byte_en === 4'hF, "R2 byte_en", {28'd0, byte_en}, 32'hF);
        chk(wr_data === sd, "R2 wr_data", wr_data, sd);
      end
    end else if (is_st) begin
      xbe = 4'd1 << ln;
      xb_wd = {4{sd[7:0]}};
      chk(wr_en === 1'b1, "R3 wr_en", {31'd0, wr_en}, 32'd1);
      chk(byte_en === xbe, "R3 byte_en", {28'd0, byte_en}, {28'd0, xbe});
      chk(wr_data === xb_wd, "R3 wr_data", wr_data, xb_wd);
    end else begin
      chk(wr_en === 1'b0, "R8 wr_en", {31'd0, wr_en}, 32'd0);
      chk(byte_en === 4'h0, "R8 byte_en", {28'd0, byte_en}, 32'd0);
    end

    word   = shadow[ea[5:2]];
    by     = word[8*ln +: 8];
    exp_lv = is_ld;
    if (op == C_LB)       begin exp_lr = {{24{by[7]}}, by}; exp_tag = "R5 LB result"; end
    else if (op == C_LBU) begin exp_lr = {24'd0, by};       exp_tag = "R6 LBU result"; end
    else                  begin exp_lr = word; exp_tag = mis ? "R4 misaligned LW result" : "R7 LW result"; end

    if (is_st && !mis) begin
      if (op == C_SW) shadow[ea[5:2]] = sd;
      else            shadow[ea[5:2]][8*ln +: 8] = sd[7:0];
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin bmem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    chk(load_valid === 1'b0, "R9 reset load_valid", {31'd0, load_valid}, 32'd0);
    chk(load_result === 32'd0, "R9 reset load_result", load_result, 32'd0);
    chk(wr_en === 1'b0, "R8 reset wr_en", {31'd0, wr_en}, 32'd0);
    rst_n = 1'b1;

    // Worked example: word 0x3F5, signed byte at +1 gives 3
    issue(1, C_SW,  32'h40, 12'h000, 32'h0000_03F5);
    issue(1, C_LB,  32'h40, 12'h001, 0);
    issue(1, C_LBU, 32'h41, 12'h000, 0);
    issue(1, C_LB,  32'h40, 12'h000, 0);   // 0xFFFFFFF5
    issue(1, C_LBU, 32'h40, 12'h000, 0);   // 0x000000F5

    // Fill all words with a negative offset
    for (int w = 0; w < 16; w++) issue(1, C_SW, 32'(32'h1040 + 4 * w), 12'hFC0, pat(w));

    // Byte loads over every word and lane, both extensions
    for (int w = 0; w < 16; w++)
      for (int l = 0; l < 4; l++) begin
        issue(1, C_LB,  32'(32'h1005 + 4 * w + l), 12'hFFB, 0);
        issue(1, C_LBU, 32'(32'h0FF0 + 4 * w + l), 12'h010, 0);
      end

    for (int w = 0; w < 16; w++) issue(1, C_LW, 32'(32'h2000 + 4 * w), 12'h000, 0);

    // Byte stores to every lane, each right after a byte load of another lane
    for (int w = 0; w < 16; w++)
      for (int l = 0; l < 4; l++) begin
        issue(1, C_LB, 32'(32'h2000 + 4 * w), 12'(3 - l), 0);
        issue(1, C_SB, 32'(32'h2000 + 4 * w + l), 12'h000, {24'hC0FFEE, 8'(w * 16 + l * 5 + 8'h70)});
      end
    for (int w = 0; w < 16; w++) issue(1, C_LW, 32'(32'h3000 + 4 * w), 12'h000, 0);

    // Misaligned word accesses
    for (int l = 1; l < 4; l++) begin
      issue(1, C_SW, 32'(32'h3010 + l), 12'h000, 32'hBAD0_BAD0);
      issue(1, C_LW, 32'(32'h3020 + l), 12'h000, 0);
    end
    issue(1, C_LW, 32'h3010, 12'h000, 0);

    // No-write cases: undefined codes and idle strobes
    for (int c = 5; c < 8; c++) issue(1, 3'(c), 32'h3004, 12'h000, 32'h1111_1111);
    issue(0, C_SW, 32'h3004, 12'h000, 32'h2222_2222);
    issue(0, C_SB, 32'h3005, 12'h000, 32'h3333_3333);
    issue(0, C_LB, 32'h3005, 12'h000, 0);
    issue(1, C_LW, 32'h3004, 12'h000, 0);

    // Address wrap in both directions
    issue(1, C_LW,  32'hFFFF_FFF8, 12'h00C, 0);
    issue(1, C_LB,  32'h0000_0002, 12'h800, 0);
    issue(1, C_LBU, 32'h7FFF_FFFF, 12'h7FF, 0);
    issue(0, C_LW,  32'h0, 12'h000, 0);
    issue(0, C_LW,  32'h0, 12'h000, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule